// File: doc/BRIEF.md
# Foreground sprite line evaluator

Before each display line, while the horizontal blanking interval runs, this block looks at every entry of a 128-entry foreground sprite table and picks out the sprites whose 16-pixel-tall extent covers the line that is about to be drawn. The table sits in a memory of 16-bit words with a synchronous read port. Each entry takes two words, and the block reads both halves to rebuild one 32-bit entry.

For every sprite that covers the line, the block emits one record on a valid/ready stream. The record carries the horizontal position, tile index, palette index, both flip bits and the row of the tile that the pixel fetcher must read. Records leave in ascending table order, so the compositor can honour the rule that a lower entry is drawn before a higher one. A global foreground-enable flag is sampled together with the start pulse. A single-cycle done pulse marks the end of the scan, and a sticky flag reports sprites that were dropped because the per-line limit was reached.

Top module: `sprite_line_eval`

## Requirements
- R1: Entry i is built from two words. The word at address 2*i supplies bits 31..16 and the word at 2*i+1 supplies bits 15..0. The memory returns data one cycle after the address is presented with `mem_rd_o` high. The fields are: bit 31 horizontal flip, bit 30 vertical flip, bits 29..21 horizontal position (9 bits), bits 20..13 vertical position (8 bits), bits 12..10 palette, bits 9..0 tile.
- R2: For line L, d is defined as L + 16 - vpos, computed without wraparound. An entry is a hit exactly when 0 <= d <= 15. With vpos = 0 an entry is never a hit.
- R3: The emitted row is d when the vertical flip bit is 0, and 15 - d when it is 1. Position, tile, palette and both flips are passed through unchanged.
- R4: Hits are emitted in ascending entry order. A record stays valid with a stable payload until `hit_ready_i` is sampled high.
- R5: At most 16 records are emitted per scan. A hit found after that sets `overflow_o`, which stays set until the next accepted start clears it.
- R6: `fetch_en_i` is sampled with the start pulse. When it is 0, the scan emits no records and `done_o` is high in the cycle right after the start edge.
- R7: `done_o` is a one-cycle pulse. With `hit_ready_i` held high and H records emitted, it is high in the cycle that follows the clock edge 3*128 + H edges after the start edge.
- R8: A start pulse that arrives while a scan is in progress is ignored. It changes neither the record stream nor the done timing.
- R9: After reset, `hit_valid_o`, `done_o`, `overflow_o` and `mem_rd_o` are all low.

## Ports
| Port | Direction | Width | Description |
|-|-|-|-|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a scan (taken only when idle) |
| line_i | input | 8 | Line number to evaluate, sampled with start |
| fetch_en_i | input | 1 | Global foreground enable, sampled with start |
| mem_rd_o | output | 1 | Read strobe to attribute memory |
| mem_addr_o | output | 8 | Word address to attribute memory |
| mem_data_i | input | 16 | Read data, one cycle after the address |
| hit_valid_o | output | 1 | Record valid |
| hit_ready_i | input | 1 | Downstream accepts record |
| hit_hflip_o | output | 1 | Horizontal flip of the sprite |
| hit_vflip_o | output | 1 | Vertical flip of the sprite |
| hit_xpos_o | output | 9 | Stored horizontal position (biased by -16) |
| hit_tile_o | output | 10 | Tile index |
| hit_pal_o | output | 3 | Palette index |
| hit_row_o | output | 4 | Tile row to fetch |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| overflow_o | output | 1 | Sticky: hits were dropped this scan |

## Verification
The bench targets the edges of the vertical window: d of 0 and 15, d of 16 and -1 at line 0, and vpos of 0. A design that wrapped the subtraction or used an off-by-one compare would emit or drop a record there. Vertical flip is exercised at both ends of the row range, and a sprite with all fields at their maximum catches a misplaced slice or swapped word halves. The bench checks that exactly the first sixteen of twenty hits come out, with the overflow flag set and then cleared by the next start; a design that counted wrongly or kept the flag would show a mismatch. Random back-pressure, a start pulse in the middle of a scan and a disabled scan check that records are held, that the stray start is ignored and that done arrives on its exact cycle.

// File: rtl/sle_pkg.sv
package sle_pkg;
   // 32-bit sprite entry layout (downstream decodes these positions)
   localparam int ENT_W     = 32;
   localparam int WORD_W    = 16;
   localparam int TILE_W    = 10;
   localparam int PAL_W     = 3;
   localparam int VPOS_W    = 8;
   localparam int HPOS_W    = 9;
   localparam int TILE_LSB  = 0;
   localparam int PAL_LSB   = TILE_LSB + TILE_W;
   localparam int VPOS_LSB  = PAL_LSB + PAL_W;
   localparam int HPOS_LSB  = VPOS_LSB + VPOS_W;
   localparam int VFLIP_BIT = HPOS_LSB + HPOS_W;
   localparam int HFLIP_BIT = VFLIP_BIT + 1;
   // sprite geometry
   localparam int SPR_SIZE  = 16;
   localparam int ROW_W     = $clog2(SPR_SIZE);

   typedef struct packed {
      logic              hflip;
      logic              vflip;
      logic [HPOS_W-1:0] xpos;
      logic [TILE_W-1:0] tile;
      logic [PAL_W-1:0]  pal;
      logic [ROW_W-1:0]  row;
   } hit_info_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_HI,
      ST_RD_LO,
      ST_EVAL,
      ST_EMIT,
      ST_DONE
   } scan_state_t;
endpackage

// File: rtl/sle_entry_decode.sv
module sle_entry_decode
   import sle_pkg::*;
#(
   parameter int LINE_W = 8
) (
   input  logic [ENT_W-1:0]  entry_i,
   input  logic [LINE_W-1:0] line_i,
   output logic              hit_o,
   output hit_info_t         info_o
);
   localparam int SUM_W = ((LINE_W > VPOS_W) ? LINE_W : VPOS_W) + 2;

   logic [SUM_W-1:0] sum_w, vpos_w, dist_w;
   logic [ROW_W-1:0] row_raw, row_flip;

   always_comb begin
      sum_w  = SUM_W'(line_i) + SUM_W'(SPR_SIZE);
      vpos_w = SUM_W'(entry_i[VPOS_LSB +: VPOS_W]);
      dist_w = sum_w - vpos_w;
      hit_o  = (sum_w >= vpos_w) && (dist_w < SUM_W'(SPR_SIZE));
   end

   assign row_raw = dist_w[ROW_W-1:0];

   generate
      if (SPR_SIZE == (1 << ROW_W)) begin : g_row_pow2
         assign row_flip = ~row_raw;
      end else begin : g_row_any
         assign row_flip = ROW_W'(SPR_SIZE - 1) - row_raw;
      end
   endgenerate

   always_comb begin
      info_o.hflip = entry_i[HFLIP_BIT];
      info_o.vflip = entry_i[VFLIP_BIT];
      info_o.xpos  = entry_i[HPOS_LSB +: HPOS_W];
      info_o.tile  = entry_i[TILE_LSB +: TILE_W];
      info_o.pal   = entry_i[PAL_LSB +: PAL_W];
      info_o.row   = entry_i[VFLIP_BIT] ? row_flip : row_raw;
   end
endmodule

// File: rtl/sle_scan_ctrl.sv
module sle_scan_ctrl
   import sle_pkg::*;
#(
   parameter  int N_SPRITES = 128,
   parameter  int MAX_HITS  = 16,
   localparam int IDX_W     = $clog2(N_SPRITES),
   localparam int ADDR_W    = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              fetch_en_i,
   input  logic              ent_hit_i,
   input  logic              ready_i,
   output logic              accept_o,
   output logic              cap_hi_o,
   output logic              load_hit_o,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              valid_o,
   output logic              done_o,
   output logic              overflow_o
);
   localparam int CNT_W = $clog2(MAX_HITS + 1);

   scan_state_t      st_q, st_d;
   logic [IDX_W-1:0] idx_q;
   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic             last, room, take, advance, pop;

   assign last     = (idx_q == IDX_W'(N_SPRITES - 1));
   assign room     = (cnt_q < CNT_W'(MAX_HITS));
   assign accept_o = (st_q == ST_IDLE) && start_i;
   assign take     = (st_q == ST_EVAL) && ent_hit_i && room;
   assign pop      = (st_q == ST_EMIT) && ready_i;
   assign advance  = ((st_q == ST_EVAL) && !take) || pop;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:  if (start_i) st_d = fetch_en_i ? ST_RD_HI : ST_DONE;
         ST_RD_HI: st_d = ST_RD_LO;
         ST_RD_LO: st_d = ST_EVAL;
         ST_EVAL:  st_d = take ? ST_EMIT : (last ? ST_DONE : ST_RD_HI);
         ST_EMIT:  if (ready_i) st_d = last ? ST_DONE : ST_RD_HI;
         ST_DONE:  st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         idx_q <= '0;
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (accept_o) begin
            idx_q <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
         end else begin
            if (advance && !last) idx_q <= idx_q + 1'b1;
            if (pop) cnt_q <= cnt_q + 1'b1;
            if ((st_q == ST_EVAL) && ent_hit_i && !room) ovf_q <= 1'b1;
         end
      end
   end

   assign cap_hi_o   = (st_q == ST_RD_LO);
   assign load_hit_o = take;
   assign mem_rd_o   = (st_q == ST_RD_HI) || (st_q == ST_RD_LO);
   assign mem_addr_o = {idx_q, (st_q == ST_RD_LO)};
   assign valid_o    = (st_q == ST_EMIT);
   assign done_o     = (st_q == ST_DONE);
   assign overflow_o = ovf_q;
endmodule

// File: rtl/sprite_line_eval.sv
module sprite_line_eval
   import sle_pkg::*;
#(
   parameter  int N_SPRITES = 128,
   parameter  int MAX_HITS  = 16,
   parameter  int LINE_W    = 8,
   localparam int ADDR_W    = $clog2(N_SPRITES) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [LINE_W-1:0] line_i,
   input  logic              fetch_en_i,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic [WORD_W-1:0] mem_data_i,
   output logic              hit_valid_o,
   input  logic              hit_ready_i,
   output logic              hit_hflip_o,
   output logic              hit_vflip_o,
   output logic [HPOS_W-1:0] hit_xpos_o,
   output logic [TILE_W-1:0] hit_tile_o,
   output logic [PAL_W-1:0]  hit_pal_o,
   output logic [ROW_W-1:0]  hit_row_o,
   output logic              done_o,
   output logic              overflow_o
);
   initial begin
      assert (N_SPRITES >= 2) else $error("N_SPRITES must be at least 2");
      assert (MAX_HITS >= 1) else $error("MAX_HITS must be at least 1");
      assert (LINE_W >= 1 && LINE_W <= 12) else $error("LINE_W out of range");
      assert (ENT_W == 2 * WORD_W) else $error("entry must be two words");
   end

   logic              accept, cap_hi, load_hit, ent_hit;
   logic [LINE_W-1:0] line_q;
   logic [WORD_W-1:0] hi_q;
   hit_info_t         ent_info, hit_q;

   sle_scan_ctrl #(
      .N_SPRITES(N_SPRITES),
      .MAX_HITS (MAX_HITS)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .fetch_en_i(fetch_en_i),
      .ent_hit_i (ent_hit),
      .ready_i   (hit_ready_i),
      .accept_o  (accept),
      .cap_hi_o  (cap_hi),
      .load_hit_o(load_hit),
      .mem_rd_o  (mem_rd_o),
      .mem_addr_o(mem_addr_o),
      .valid_o   (hit_valid_o),
      .done_o    (done_o),
      .overflow_o(overflow_o)
   );

   sle_entry_decode #(
      .LINE_W(LINE_W)
   ) u_dec (
      .entry_i({hi_q, mem_data_i}),
      .line_i (line_q),
      .hit_o  (ent_hit),
      .info_o (ent_info)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q <= '0;
         hi_q   <= '0;
         hit_q  <= '0;
      end else begin
         if (accept)   line_q <= line_i;
         if (cap_hi)   hi_q   <= mem_data_i;
         if (load_hit) hit_q  <= ent_info;
      end
   end

   assign hit_hflip_o = hit_q.hflip;
   assign hit_vflip_o = hit_q.vflip;
   assign hit_xpos_o  = hit_q.xpos;
   assign hit_tile_o  = hit_q.tile;
   assign hit_pal_o   = hit_q.pal;
   assign hit_row_o   = hit_q.row;
endmodule

// File: rtl/sle_checker.sv
module sle_checker #(
   parameter int MAX_HITS = 16,
   parameter int ADDR_W   = 8,
   parameter int PAY_W    = 28
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              hit_valid_o,
   input logic              hit_ready_i,
   input logic [PAY_W-1:0]  payload,
   input logic              done_o,
   input logic              overflow_o,
   input logic              mem_rd_o,
   input logic [ADDR_W-1:0] mem_addr_o
);
   localparam int CW = $clog2(MAX_HITS + 2) + 1;
   logic [CW-1:0] n_acc;

   always_ff @(posedge clk) begin
      if (!rst_n) n_acc <= '0;
      else if (done_o) n_acc <= '0;
      else if (hit_valid_o && hit_ready_i) n_acc <= n_acc + 1'b1;
   end

   // R1: a high-half read is followed by the low-half read of the same entry
   a_r1_word_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o && !mem_addr_o[0]) |=> (mem_rd_o && mem_addr_o == $past(mem_addr_o) + 1'b1));

   // R4: a stalled record holds
   a_r4_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid_o && !hit_ready_i) |=> (hit_valid_o && $stable(payload)));

   // R5: per-scan record count never exceeds the limit
   a_r5_hit_limit: assert property (@(posedge clk) disable iff (!rst_n)
      n_acc <= CW'(MAX_HITS));

   // R5: overflow stays set unless a start arrives
   a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow_o && !start_i) |=> overflow_o);

   // R7: done is a single-cycle pulse and never overlaps a record
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r7_done_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && hit_valid_o));
endmodule

bind sprite_line_eval sle_checker #(
   .MAX_HITS(MAX_HITS),
   .ADDR_W  (ADDR_W),
   .PAY_W   (28)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .hit_valid_o(hit_valid_o),
   .hit_ready_i(hit_ready_i),
   .payload    ({hit_hflip_o, hit_vflip_o, hit_xpos_o, hit_tile_o, hit_pal_o, hit_row_o}),
   .done_o     (done_o),
   .overflow_o (overflow_o),
   .mem_rd_o   (mem_rd_o),
   .mem_addr_o (mem_addr_o)
);

// File: tb/sprite_line_eval_bench.sv
module sprite_line_eval_bench;
   localparam int NS = 128;
   localparam int MH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  line_i = '0;
   logic        fetch_en_i = 1'b0;
   logic        mem_rd_o;
   logic [7:0]  mem_addr_o;
   logic [15:0] mem_data_i = '0;
   logic        hit_valid_o;
   logic        hit_ready_i = 1'b1;
   logic        hit_hflip_o, hit_vflip_o;
   logic [8:0]  hit_xpos_o;
   logic [9:0]  hit_tile_o;
   logic [2:0]  hit_pal_o;
   logic [3:0]  hit_row_o;
   logic        done_o, overflow_o;

   int checks = 0;
   int errors = 0;
   bit bp_mode = 1'b0;
   logic [15:0] mem [0:2*NS-1];
   logic [27:0] exp_q [$];

   always #5 clk = ~clk;

   sprite_line_eval u_sprite_line_eval (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .line_i(line_i),
      .fetch_en_i(fetch_en_i), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
      .mem_data_i(mem_data_i), .hit_valid_o(hit_valid_o), .hit_ready_i(hit_ready_i),
      .hit_hflip_o(hit_hflip_o), .hit_vflip_o(hit_vflip_o), .hit_xpos_o(hit_xpos_o),
      .hit_tile_o(hit_tile_o), .hit_pal_o(hit_pal_o), .hit_row_o(hit_row_o),
      .done_o(done_o), .overflow_o(overflow_o)
   );

   // synchronous-read attribute memory
   always @(posedge clk) if (mem_rd_o) mem_data_i <= mem[mem_addr_o];

   // ready driver: always high, or pseudo-random back-pressure
   initial begin
      logic [15:0] lf;
      lf = 16'hACE1;
      forever begin
         @(posedge clk);
         #1;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         hit_ready_i = bp_mode ? lf[0] : 1'b1;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // stream monitor, compared against the model queue on every clock
   always @(negedge clk) begin
      if (rst_n && hit_valid_o) begin
         logic [27:0] got;
         got = {hit_hflip_o, hit_vflip_o, hit_xpos_o, hit_tile_o, hit_pal_o, hit_row_o};
         if (exp_q.size() == 0) begin
            check(1'b0, "R2/R5", "unexpected record", longint'(got), 0);
         end else begin
            check(got == exp_q[0], "R1/R2/R3/R4", "record payload",
                  longint'(got), longint'(exp_q[0]));
            if (hit_ready_i) void'(exp_q.pop_front());
         end
      end
   end

   function automatic logic [31:0] mk(input bit hf, input bit vf, input int x,
                                      input int y, input int pal, input int tile);
      logic [31:0] e;
      e = {hf, vf, 9'(x), 8'(y), 3'(pal), 10'(tile)};
      return e;
   endfunction

   task automatic put(input int i, input logic [31:0] e);
      mem[2*i]   = e[31:16];
      mem[2*i+1] = e[15:0];
   endtask

   task automatic clear_mem();
      for (int i = 0; i < NS; i++) put(i, mk(0, 0, i, 0, i % 8, i));
   endtask

   // behavioural model: expected records and overflow for one scan
   task automatic model(input int line, input bit fen, output int nh, output bit ovf);
      nh = 0;
      ovf = 1'b0;
      exp_q.delete();
      if (!fen) return;
      for (int i = 0; i < NS; i++) begin
         logic [31:0] e;
         int d, row;
         e = {mem[2*i], mem[2*i+1]};
         d = line + 16 - int'(e[20:13]);
         if (d >= 0 && d < 16) begin
            if (nh < MH) begin
               row = e[30] ? 15 - d : d;
               exp_q.push_back({e[31], e[30], e[29:21], e[9:0], e[12:10], 4'(row)});
               nh++;
            end else begin
               ovf = 1'b1;
            end
         end
      end
   endtask

   task automatic run_scan(input int line, input bit fen, input bit bp, input bit mid_start);
      int nh, k;
      bit ovf, got;
      model(line, fen, nh, ovf);
      bp_mode = bp;
      @(posedge clk);
      #1;
      start_i = 1'b1;
      line_i = 8'(line);
      fetch_en_i = fen;
      @(posedge clk);
      #1;
      start_i = 1'b0;
      line_i = 8'(line + 37);
      fetch_en_i = ~fen;
      k = 0;
      got = 1'b0;
      while (!got && k < 3000) begin
         @(negedge clk);
         k++;
         if (k == 1) check(overflow_o == 1'b0, "R5", "overflow cleared by start", overflow_o, 0);
         if (done_o) got = 1'b1;
         else begin
            @(posedge clk);
            #1;
            start_i = mid_start && (k == 50);
         end
      end
      start_i = 1'b0;
      check(got, "R7", "done seen", got, 1);
      if (!bp) check(k == (fen ? 3 * NS + nh + 1 : 1), "R7/R8", "done cycle", k,
                     fen ? 3 * NS + nh + 1 : 1);
      check(exp_q.size() == 0, "R4/R5", "records left undelivered", exp_q.size(), 0);
      check(overflow_o == ovf, "R5", "overflow at done", overflow_o, ovf);
      @(negedge clk);
      check(done_o == 1'b0, "R7", "done single cycle", done_o, 0);
      bp_mode = 1'b0;
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      clear_mem();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      check(hit_valid_o == 0, "R9", "valid after reset", hit_valid_o, 0);
      check(done_o == 0, "R9", "done after reset", done_o, 0);
      check(overflow_o == 0, "R9", "overflow after reset", overflow_o, 0);
      check(mem_rd_o == 0, "R9", "read strobe after reset", mem_rd_o, 0);

      // R1 R2 R3: mixed flips, window edges, max field values, last entry
      clear_mem();
      put(3,   mk(0, 0, 100, 50, 2, 17));
      put(10,  mk(0, 1, 5, 41, 5, 300));
      put(20,  mk(1, 1, 9, 40, 1, 1));
      put(21,  mk(1, 0, 9, 57, 1, 2));
      put(77,  mk(1, 0, 511, 56, 7, 1023));
      put(127, mk(1, 1, 256, 45, 4, 512));
      run_scan(40, 1'b1, 1'b0, 1'b0);
      // R4: same table under random back-pressure
      run_scan(40, 1'b1, 1'b1, 1'b0);
      // R8: stray start mid-scan
      run_scan(40, 1'b1, 1'b0, 1'b1);

      // R2: line 0 boundaries, no wraparound
      clear_mem();
      put(0, mk(0, 0, 1, 1, 3, 11));
      put(1, mk(0, 1, 2, 16, 3, 12));
      put(2, mk(1, 0, 3, 17, 3, 13));
      put(5, mk(0, 0, 4, 0, 3, 14));
      run_scan(0, 1'b1, 1'b0, 1'b0);
      // R2: bottom line
      put(6, mk(0, 0, 7, 255, 6, 15));
      put(7, mk(0, 1, 8, 250, 6, 16));
      run_scan(255, 1'b1, 1'b0, 1'b0);

      // R5: twenty hits, sixteen emitted, overflow set
      clear_mem();
      for (int i = 0; i < 20; i++) put(i * 6, mk(i[0], i[1], i * 20, 110 - (i % 10), i % 8, 1000 - i));
      run_scan(100, 1'b1, 1'b1, 1'b0);
      // R6: disabled scan, no records, clears overflow
      run_scan(100, 1'b0, 1'b0, 1'b0);
      run_scan(100, 1'b1, 1'b0, 1'b0);
      // R5: next start clears overflow and a quiet line leaves it clear
      run_scan(10, 1'b1, 1'b0, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule